// File: doc/BRIEF.md
# Page Write Latch with Word-Order Checking

This block is a single-page staging buffer placed between the system bus and a flash programming engine. Software writes the data for one page into it before it issues a program command. The buffer repeats across the whole flash address window. Any byte address selects a 32-bit word by its offset inside the 512-byte page, and the address bits above the page are ignored. The block accepts only full, aligned 32-bit writes. The words of one page must arrive as a continuous run that either climbs or falls one word at a time.

A small state machine follows the run. It has four states:
- ST_EMPTY: no word has been accepted yet.
- ST_ONE: one word has been accepted and the direction is still open.
- ST_UP: the run is ascending.
- ST_DOWN: the run is descending.

It has these transitions:
- Start: ST_EMPTY goes to ST_ONE on any legal write.
- Climb: ST_ONE goes to ST_UP on a write at the next higher offset.
- Fall: ST_ONE goes to ST_DOWN on a write at the next lower offset.
- Continue: ST_UP and ST_DOWN stay in place on a write that follows the run.
- Restart: any state goes to ST_EMPTY when the clear-order pulse arrives.

A write that breaks the run is refused and raises a sticky order-error flag. An aligned-width violation is refused and raises a sticky access-error flag.

The programming engine pulses the clear-order input when it issues a command. It pulses the fill input once the command has executed, and this sets every bit of the page to one. The engine reads the page back through a registered port indexed by word offset, one word per cycle. Reset clears only the order tracking and the flags. The page contents are left as they are.

Top module: `page_latch`

## Requirements
- R1: A legal write stores wr_data in the word whose offset is wr_addr[8:2]. Every address bit above bit 8 is ignored, so the page repeats across the window.
- R2: A write is illegal if wr_be is not 4'b1111 or if wr_addr[1:0] is not 2'b00. An illegal write sets acc_err and changes neither the buffer nor the order tracking.
- R3: The first legal write after reset or clear_order is accepted at any offset. The second accepted write fixes the direction: offset+1 makes the run ascending and offset-1 makes it descending.
- R4: An ascending run accepts only the previous offset plus one, and offset 127 is followed by 0. A descending run accepts only the previous offset minus one, and offset 0 is followed by 127.
- R5: A legal-width write that breaks the run sets ord_err. The write is not stored, and the tracking keeps the last accepted offset and direction.
- R6: One cycle after a fill_ones pulse, every word of the buffer reads 32'hFFFF_FFFF.
- R7: After a clear_order pulse, acc_err and ord_err read 0 in the next cycle and tracking returns to ST_EMPTY.
- R8: A write presented in the same cycle as fill_ones or clear_order is ignored completely. It sets no flag and stores nothing.
- R9: Reset clears both flags and the tracking state, and it does not write the buffer contents.
- R10: rd_data returns the word at rd_idx one clock after rd_idx is sampled.
- R11: acc_err and ord_err are sticky. They stay set until clear_order or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 20 | Byte address inside the flash window |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables |
| clear_order | input | 1 | Pulse at program command: restart tracking and clear flags |
| fill_ones | input | 1 | Pulse after a command executes: set the page to all ones |
| rd_idx | input | 7 | Word offset to read |
| rd_data | output | 32 | Registered read data |
| acc_err | output | 1 | Sticky illegal-width/alignment flag |
| ord_err | output | 1 | Sticky out-of-order flag |

## Verification
The flags, the stored word and the refill all take effect at the clock edge that samples the strobe. The bench drives a strobe just after one falling edge and checks flags and state at the next falling edge, which is exactly one rising edge later. Read data is due one rising edge after rd_idx is sampled. The bench therefore sets rd_idx at a falling edge and compares rd_data at the following falling edge. Random runs in both directions, with wrap-around, illegal widths and broken orders mixed in, are compared word by word against a bench model of the page.

// File: rtl/plb_pkg.sv
package plb_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_ONE   = 2'd1,
        ST_UP    = 2'd2,
        ST_DOWN  = 2'd3
    } run_state_e;
endpackage

// File: rtl/plb_access_check.sv
module plb_access_check #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32,
    parameter int PAGE_WORDS = 128,
    localparam int LANES = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES),
    localparam int OFF_W = $clog2(PAGE_WORDS)
) (
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANES-1:0]  be_i,
    input  logic              block_i,
    output logic              legal_vld_o,
    output logic              illegal_o,
    output logic [OFF_W-1:0]  off_o
);
    logic full_word;
    logic aligned;

    always_comb begin
        full_word   = &be_i;
        aligned     = (addr_i[LANE_W-1:0] == '0);
        off_o       = addr_i[LANE_W +: OFF_W];
        legal_vld_o = wr_en_i && !block_i && full_word && aligned;
        illegal_o   = wr_en_i && !block_i && !(full_word && aligned);
    end
endmodule

// File: rtl/plb_order_fsm.sv
module plb_order_fsm
    import plb_pkg::*;
#(
    parameter int PAGE_WORDS = 128,
    localparam int OFF_W = $clog2(PAGE_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             wr_vld_i,
    input  logic [OFF_W-1:0] off_i,
    output logic             accept_o,
    output logic             brk_o
);
    run_state_e       state_q, state_d;
    logic [OFF_W-1:0] last_q, last_d;
    logic             is_next, is_prev;

    always_comb begin
        is_next = (off_i == OFF_W'(last_q + 1'b1));
        is_prev = (off_i == OFF_W'(last_q - 1'b1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            last_q  <= '0;
        end else begin
            state_q <= state_d;
            last_q  <= last_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = ST_EMPTY;
        end else if (wr_vld_i) begin
            unique case (state_q)
                ST_EMPTY: state_d = ST_ONE;
                ST_ONE: begin
                    if (is_next)      state_d = ST_UP;
                    else if (is_prev) state_d = ST_DOWN;
                end
                ST_UP:   state_d = ST_UP;
                ST_DOWN: state_d = ST_DOWN;
                default: state_d = ST_EMPTY;
            endcase
        end
    end

    always_comb begin
        accept_o = 1'b0;
        brk_o    = 1'b0;
        if (wr_vld_i && !clr_i) begin
            unique case (state_q)
                ST_EMPTY: accept_o = 1'b1;
                ST_ONE:   accept_o = is_next || is_prev;
                ST_UP:    accept_o = is_next;
                ST_DOWN:  accept_o = is_prev;
                default:  accept_o = 1'b0;
            endcase
            brk_o = !accept_o;
        end
        last_d = accept_o ? off_i : last_q;
    end

    p_first_any_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY && wr_vld_i && !clr_i) |-> accept_o);
    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept_o && brk_o));
    p_brk_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        brk_o |=> (last_q == $past(last_q)) && (state_q == $past(state_q)));
    p_clr_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> state_q == ST_EMPTY);
    p_dir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP && !clr_i) |=> state_q == ST_UP);
endmodule

// File: rtl/plb_word_store.sv
module plb_word_store #(
    parameter int DATA_W = 32,
    parameter int PAGE_WORDS = 128,
    localparam int OFF_W = $clog2(PAGE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_i,
    input  logic              we_i,
    input  logic [OFF_W-1:0]  wr_off_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [OFF_W-1:0]  rd_off_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] words [PAGE_WORDS];

    for (genvar gi = 0; gi < PAGE_WORDS; gi++) begin : g_word
        always_ff @(posedge clk) begin
            if (fill_i)
                words[gi] <= '1;
            else if (we_i && wr_off_i == OFF_W'(gi))
                words[gi] <= wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        rd_data_o <= words[rd_off_i];
    end

    p_fill_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_i |=> (&words[0]) && (&words[PAGE_WORDS-1]));
    p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !fill_i) |=> words[$past(wr_off_i)] == $past(wr_data_i));
endmodule

// File: rtl/page_latch.sv
module page_latch
    import plb_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32,
    parameter int PAGE_WORDS = 128,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(PAGE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    input  logic              clear_order,
    input  logic              fill_ones,
    input  logic [OFF_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              acc_err,
    output logic              ord_err
);
    logic             blocked;
    logic             legal_vld;
    logic             illegal;
    logic [OFF_W-1:0] off;
    logic             accept;
    logic             brk;

    assign blocked = fill_ones || clear_order;

    plb_access_check #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS)
    ) u_chk (
        .wr_en_i(wr_en), .addr_i(wr_addr), .be_i(wr_be), .block_i(blocked),
        .legal_vld_o(legal_vld), .illegal_o(illegal), .off_o(off)
    );

    plb_order_fsm #(.PAGE_WORDS(PAGE_WORDS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .clr_i(clear_order),
        .wr_vld_i(legal_vld && !fill_ones), .off_i(off),
        .accept_o(accept), .brk_o(brk)
    );

    plb_word_store #(.DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS)) u_store (
        .clk(clk), .rst_n(rst_n), .fill_i(fill_ones), .we_i(accept),
        .wr_off_i(off), .wr_data_i(wr_data), .rd_off_i(rd_idx),
        .rd_data_o(rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_err <= 1'b0;
            ord_err <= 1'b0;
        end else if (clear_order) begin
            acc_err <= 1'b0;
            ord_err <= 1'b0;
        end else begin
            if (illegal) acc_err <= 1'b1;
            if (brk)     ord_err <= 1'b1;
        end
    end

    p_acc_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !blocked && !(&wr_be)) |=> acc_err);
    p_acc_nostore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !accept);
    p_clr_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_order |=> !acc_err && !ord_err);
    p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> !accept && !brk && !illegal);
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_err && !clear_order) |=> acc_err);
endmodule

// File: tb/page_latch_bench.sv
module page_latch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic        clear_order = 1'b0;
    logic        fill_ones = 1'b0;
    logic [6:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        acc_err, ord_err;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_mem [128];
    int  m_state = 0;
    int  m_last = 0;
    bit  m_acc = 0;
    bit  m_ord = 0;

    always #5 clk = ~clk;

    page_latch u_page_latch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .clear_order(clear_order),
        .fill_ones(fill_ones), .rd_idx(rd_idx), .rd_data(rd_data),
        .acc_err(acc_err), .ord_err(ord_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int step_of(input int last, input int dlt);
        return (last + dlt + 128) % 128;
    endfunction

    task automatic model_write(input logic [19:0] a, input logic [31:0] d,
                               input logic [3:0] be);
        int  off;
        bit  ok;
        if (be != 4'hF || a[1:0] != 2'b00) begin
            m_acc = 1;
            return;
        end
        off = int'(a[8:2]);
        ok  = 0;
        case (m_state)
            0: begin ok = 1; m_state = 1; end
            1: if (off == step_of(m_last, 1)) begin ok = 1; m_state = 2; end
               else if (off == step_of(m_last, -1)) begin ok = 1; m_state = 3; end
            2: ok = (off == step_of(m_last, 1));
            3: ok = (off == step_of(m_last, -1));
            default: ok = 0;
        endcase
        if (ok) begin
            exp_mem[off] = d;
            m_last = off;
        end else begin
            m_ord = 1;
        end
    endtask

    task automatic bus_wr(input logic [19:0] a, input logic [31:0] d,
                          input logic [3:0] be);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d, be);
    endtask

    function automatic logic [19:0] mk_addr(input int off);
        logic [10:0] hi;
        hi = 11'($urandom);
        return {hi, 7'(off), 2'b00};
    endfunction

    task automatic do_clear();
        @(negedge clk);
        clear_order = 1'b1;
        @(negedge clk);
        clear_order = 1'b0;
        m_state = 0; m_acc = 0; m_ord = 0;
    endtask

    task automatic do_fill();
        @(negedge clk);
        fill_ones = 1'b1;
        @(negedge clk);
        fill_ones = 1'b0;
        for (int i = 0; i < 128; i++) exp_mem[i] = '1;
    endtask

    task automatic chk_flags(input string req);
        chk(acc_err == m_acc, {req, " acc_err"}, 32'(acc_err), 32'(m_acc));
        chk(ord_err == m_ord, {req, " ord_err"}, 32'(ord_err), 32'(m_ord));
    endtask

    task automatic rd_chk(input int idx, input string req);
        @(negedge clk);
        rd_idx = 7'(idx);
        @(negedge clk);
        chk(rd_data == exp_mem[idx], req, rd_data, exp_mem[idx]);
    endtask

    task automatic rd_all(input string req);
        for (int i = 0; i < 128; i++) rd_chk(i, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state of flags
        chk_flags("R9 reset");

        // R6: fill sets all ones
        do_fill();
        rd_all("R6 fill ones");

        // R1/R3: first write anywhere, upper bits ignored
        bus_wr(20'hABC14, 32'h1111_0005, 4'hF);
        rd_chk(5, "R1 wrap address");
        // R3/R4 ascending with wrap 127 -> 0
        do_clear(); do_fill();
        bus_wr(mk_addr(126), 32'hA126, 4'hF);
        bus_wr(mk_addr(127), 32'hA127, 4'hF);
        bus_wr(mk_addr(0),   32'hA000, 4'hF);
        bus_wr(mk_addr(1),   32'hA001, 4'hF);
        chk_flags("R4 ascending wrap");
        rd_chk(0, "R4 ascending wrap");
        rd_chk(1, "R4 ascending wrap");
        // R5: break the ascending run
        bus_wr(mk_addr(0), 32'hBAD0, 4'hF);
        chk_flags("R5 order break");
        rd_chk(0, "R5 not stored");
        bus_wr(mk_addr(2), 32'hA002, 4'hF);
        rd_chk(2, "R5 run resumes");
        // R11: flag stays
        chk_flags("R11 sticky");

        // R4 descending with wrap 0 -> 127
        do_clear();
        chk_flags("R7 clear");
        bus_wr(mk_addr(1),   32'hD001, 4'hF);
        bus_wr(mk_addr(0),   32'hD000, 4'hF);
        bus_wr(mk_addr(127), 32'hD127, 4'hF);
        chk_flags("R4 descending wrap");
        rd_chk(127, "R4 descending wrap");

        // R2: byte and misaligned writes rejected
        bus_wr(mk_addr(126), 32'h0000_00EE, 4'h1);
        bus_wr(mk_addr(126) | 20'h2, 32'hEEEE_EEEE, 4'hF);
        chk_flags("R2 illegal access");
        rd_chk(126, "R2 buffer unchanged");
        bus_wr(mk_addr(126), 32'hD126, 4'hF);
        rd_chk(126, "R2 tracking unchanged");

        // R8: write together with fill_ones is ignored
        do_clear();
        @(negedge clk);
        wr_en = 1'b1; wr_addr = mk_addr(50); wr_data = 32'h5555_0000; wr_be = 4'h1;
        fill_ones = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; fill_ones = 1'b0;
        for (int i = 0; i < 128; i++) exp_mem[i] = '1;
        chk_flags("R8 ignored with fill");
        rd_chk(50, "R8 ignored with fill");
        // R8: write together with clear_order ignored
        bus_wr(mk_addr(10), 32'h0000_0010, 4'hF);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = mk_addr(70); wr_data = 32'h7070_7070; wr_be = 4'hF;
        clear_order = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; clear_order = 1'b0;
        m_state = 0; m_acc = 0; m_ord = 0;
        rd_chk(70, "R8 ignored with clear");
        // R7: after clear, any offset accepted
        bus_wr(mk_addr(90), 32'h0000_0090, 4'hF);
        chk_flags("R7 restart");
        rd_chk(90, "R7 restart");

        // R9: reset keeps buffer contents
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_state = 0; m_acc = 0; m_ord = 0;
        chk_flags("R9 reset flags");
        rd_chk(90, "R9 contents kept");

        // Constrained random runs (R1 R3 R4 R5 R2 R10)
        for (int round = 0; round < 8; round++) begin
            int start, dir, len, off;
            do_clear(); do_fill();
            start = int'($urandom % 128);
            dir   = ($urandom % 2) ? 1 : -1;
            len   = 1 + int'($urandom % 140);
            off   = start;
            for (int k = 0; k < len; k++) begin
                int pick = int'($urandom % 16);
                if (pick == 0)
                    bus_wr(mk_addr(off), $urandom, 4'($urandom % 15));
                else if (pick == 1)
                    bus_wr(mk_addr(int'($urandom % 128)), $urandom, 4'hF);
                else begin
                    bus_wr(mk_addr(off), $urandom, 4'hF);
                    off = step_of(m_last, dir);
                end
            end
            chk_flags("R5 random flags");
            rd_all("R10 random readback");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule